// File: doc/BRIEF.md
# Linear Address Generator

This block turns a memory operand description into a linear address. A request carries a base register value and its register number, an optional index value with a two-bit scale code, a 32-bit signed displacement, an optional segment override, a flag for 64-bit operation and a flag that selects the plain offset result. The block adds the scaled index and the sign-extended displacement to the base. It then adds the base of the selected segment, taken from a six-entry table supplied as one flat bus.

The segment is picked implicitly from the base register number unless an override is present. In 64-bit operation most segment bases count as zero. When the segment term is zero, or when the offset-only mode is selected, the result appears one cycle after the request is accepted. Otherwise the block spends one extra cycle on the segment add. During that cycle it drops its ready output, and any request offered then is not taken.

Top module: `agu_linear`

## Requirements
- R1: While `rst` is high and in the cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: The offset is base + (index << scale_code) + displacement, computed modulo 2^64. Scale codes 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8. The displacement is sign-extended from bit 31.
- R3: When `index_en` is 0, the index value has no effect on the result.
- R4: When `lea_mode` is 1, the result is the offset alone, with no segment term. It appears one cycle after acceptance, and no stall occurs.
- R5: Segment numbers are ES=0, CS=1, SS=2, DS=3, FS=4 and GS=5. Without an override, the segment is SS when `base_id` is 4 or 5, and DS for any other value. With `seg_ovr_en` set, `seg_ovr_sel` picks the segment. Values 6 and 7 give a zero base.
- R6: When `long_mode` is 1, every segment base except FS and GS counts as zero.
- R7: If the effective segment base is zero, `out_valid` rises one cycle after acceptance, carrying the address, and `in_ready` stays 1.
- R8: If the effective segment base is nonzero, `in_ready` is 0 in the cycle after acceptance. `out_valid` rises in the cycle after that, with segment base + offset. A request offered while `in_ready` is 0 is ignored.
- R9: `out_valid` is high for exactly one cycle per accepted request, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request this cycle |
| lea_mode | input | 1 | Return offset only, no segment term |
| long_mode | input | 1 | 64-bit operation: segment bases other than FS/GS count as zero |
| base_val | input | 64 | Base register value |
| base_id | input | 4 | Base register number (4 and 5 imply SS) |
| index_val | input | 64 | Index register value |
| index_en | input | 1 | Index term present |
| scale_code | input | 2 | Index shift amount 0..3 |
| disp | input | 32 | Signed displacement |
| seg_ovr_en | input | 1 | Use `seg_ovr_sel` instead of the default segment |
| seg_ovr_sel | input | 3 | Override segment number |
| seg_bases | input | 384 | Six 64-bit segment bases, entry n at bits n*64 upward |
| out_valid | output | 1 | Result strobe |
| out_addr | output | 64 | Linear address or offset |

## Verification
The bench builds the block with its defaults: a 64-bit address, a 32-bit displacement, a 4-bit register number and six segments. With these, the sign extension of negative displacements and the wrap of sums past 2^64 can be checked. So can the full SS-by-default register numbers and the out-of-range override codes 6 and 7. The segment table mixes zero and nonzero bases, so both the one-cycle and the two-cycle path appear, in legacy and 64-bit operation. A request held during a stall shows that the extra cycle drops the offered request.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    SEG_ES = 3'd0,
    SEG_CS = 3'd1,
    SEG_SS = 3'd2,
    SEG_DS = 3'd3,
    SEG_FS = 3'd4,
    SEG_GS = 3'd5
  } seg_num_e;

  // register numbers that imply the stack segment
  localparam int unsigned REG_STACK_PTR = 4;
  localparam int unsigned REG_FRAME_PTR = 5;
endpackage

// File: rtl/agu_seg_select.sv
module agu_seg_select #(
  parameter int ADDR_W    = 64,
  parameter int SEG_CNT   = 6,
  parameter int SEG_SEL_W = $clog2(SEG_CNT),
  parameter int REG_ID_W  = 4
) (
  input  logic [REG_ID_W-1:0]       base_id,
  input  logic                      ovr_en,
  input  logic [SEG_SEL_W-1:0]      ovr_sel,
  input  logic                      long_mode,
  input  logic [SEG_CNT*ADDR_W-1:0] seg_bases,
  output logic [ADDR_W-1:0]         seg_base
);
  import agu_pkg::*;

  logic [ADDR_W-1:0]    eff_base [SEG_CNT];
  logic [SEG_SEL_W-1:0] sel;
  logic                 stack_reg;

  // per-entry base after the 64-bit zeroing rule
  for (genvar g = 0; g < SEG_CNT; g++) begin : g_entry
    localparam bit KEEP_LONG = (g == int'(SEG_FS)) || (g == int'(SEG_GS));
    if (KEEP_LONG) begin : g_keep
      assign eff_base[g] = seg_bases[g*ADDR_W +: ADDR_W];
    end else begin : g_flat
      assign eff_base[g] = long_mode ? '0 : seg_bases[g*ADDR_W +: ADDR_W];
    end
  end

  assign stack_reg = (base_id == REG_ID_W'(REG_STACK_PTR)) ||
                     (base_id == REG_ID_W'(REG_FRAME_PTR));

  always_comb begin
    if (ovr_en)         sel = ovr_sel;
    else if (stack_reg) sel = SEG_SEL_W'(SEG_SS);
    else                sel = SEG_SEL_W'(SEG_DS);
  end

  always_comb begin
    seg_base = '0;
    for (int i = 0; i < SEG_CNT; i++) begin
      if (sel == SEG_SEL_W'(i)) seg_base = eff_base[i];
    end
  end
endmodule

// File: rtl/agu_offset.sv
module agu_offset #(
  parameter int ADDR_W  = 64,
  parameter int DISP_W  = 32,
  parameter int SCALE_W = 2
) (
  input  logic [ADDR_W-1:0]  base_val,
  input  logic [ADDR_W-1:0]  index_val,
  input  logic               index_en,
  input  logic [SCALE_W-1:0] scale_code,
  input  logic [DISP_W-1:0]  disp,
  output logic [ADDR_W-1:0]  offset
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] scaled;
  logic [ADDR_W-1:0] disp_ext;

  assign scaled   = index_en ? (index_val << scale_code) : '0;
  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign offset   = base_val + scaled + disp_ext;
endmodule

// File: rtl/agu_linear.sv
module agu_linear #(
  parameter int ADDR_W    = 64,
  parameter int DISP_W    = 32,
  parameter int REG_ID_W  = 4,
  parameter int SEG_CNT   = 6,
  parameter int SEG_SEL_W = $clog2(SEG_CNT),
  parameter int SCALE_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic                      lea_mode,
  input  logic                      long_mode,
  input  logic [ADDR_W-1:0]         base_val,
  input  logic [REG_ID_W-1:0]       base_id,
  input  logic [ADDR_W-1:0]         index_val,
  input  logic                      index_en,
  input  logic [SCALE_W-1:0]        scale_code,
  input  logic [DISP_W-1:0]         disp,
  input  logic                      seg_ovr_en,
  input  logic [SEG_SEL_W-1:0]      seg_ovr_sel,
  input  logic [SEG_CNT*ADDR_W-1:0] seg_bases,
  output logic                      out_valid,
  output logic [ADDR_W-1:0]         out_addr
);
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] seg_base;
  logic              accept;
  logic              seg_zero;
  logic              busy;
  logic [ADDR_W-1:0] hold_off;
  logic [ADDR_W-1:0] hold_seg;

  agu_offset #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W),
    .SCALE_W(SCALE_W)
  ) u_offset (
    .base_val  (base_val),
    .index_val (index_val),
    .index_en  (index_en),
    .scale_code(scale_code),
    .disp      (disp),
    .offset    (offset)
  );

  agu_seg_select #(
    .ADDR_W   (ADDR_W),
    .SEG_CNT  (SEG_CNT),
    .SEG_SEL_W(SEG_SEL_W),
    .REG_ID_W (REG_ID_W)
  ) u_seg (
    .base_id  (base_id),
    .ovr_en   (seg_ovr_en),
    .ovr_sel  (seg_ovr_sel),
    .long_mode(long_mode),
    .seg_bases(seg_bases),
    .seg_base (seg_base)
  );

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign seg_zero = lea_mode || (seg_base == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      out_valid <= 1'b0;
      out_addr  <= '0;
      hold_off  <= '0;
      hold_seg  <= '0;
    end else if (busy) begin
      // second cycle of the slow path: add the segment term
      busy      <= 1'b0;
      out_valid <= 1'b1;
      out_addr  <= hold_seg + hold_off;
    end else if (accept && seg_zero) begin
      out_valid <= 1'b1;
      out_addr  <= offset;
    end else if (accept) begin
      busy      <= 1'b1;
      out_valid <= 1'b0;
      hold_off  <= offset;
      hold_seg  <= seg_base;
    end else begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/agu_checker.sv
module agu_checker (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic lea_mode,
  input logic out_valid
);
  // R1: reset leaves the result strobe low and the block ready
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));

  // R8: a stall lasts exactly one cycle
  assert_stall_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> in_ready);

  // R8: the slow result follows the stall cycle
  assert_stall_then_result_R8: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> out_valid);

  // R4: offset-only requests never stall and answer next cycle
  assert_lea_fast_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && lea_mode) |=> (out_valid && in_ready));

  // R9: no strobe without an acceptance or stall just before
  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(in_valid && in_ready) || $past(!in_ready)));
endmodule

bind agu_linear agu_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .lea_mode (lea_mode),
  .out_valid(out_valid)
);

// File: tb/agu_linear_bench.sv
module agu_linear_bench;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid, in_ready, lea_mode, long_mode;
  logic [63:0]  base_val, index_val;
  logic [3:0]   base_id;
  logic         index_en;
  logic [1:0]   scale_code;
  logic [31:0]  disp;
  logic         seg_ovr_en;
  logic [2:0]   seg_ovr_sel;
  logic [383:0] seg_bases;
  logic         out_valid;
  logic [63:0]  out_addr;

  int errors = 0;
  int checks = 0;

  logic [63:0] segtab [6];

  // expectations for the interval after the coming edge
  bit          exp_v, exp_ready, slow_pend;
  logic [63:0] exp_addr, slow_addr;
  string       exp_tag, slow_tag;

  always #10 clk = ~clk;

  agu_linear u_agu_linear (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .lea_mode(lea_mode), .long_mode(long_mode), .base_val(base_val),
    .base_id(base_id), .index_val(index_val), .index_en(index_en),
    .scale_code(scale_code), .disp(disp), .seg_ovr_en(seg_ovr_en),
    .seg_ovr_sel(seg_ovr_sel), .seg_bases(seg_bases),
    .out_valid(out_valid), .out_addr(out_addr)
  );

  function automatic logic [63:0] model_seg(input logic [3:0] bid, input bit oe,
                                            input logic [2:0] os, input bit lm);
    int s;
    s = oe ? int'(os) : ((bid == 4 || bid == 5) ? 2 : 3);
    if (s > 5) return 64'd0;
    if (lm && s != 4 && s != 5) return 64'd0;
    return segtab[s];
  endfunction

  task automatic fail_line(input string tag, input logic [63:0] act, input logic [63:0] exp);
    errors++;
    $display("FAIL %s actual=%h expected=%h", tag, act, exp);
  endtask

  task automatic compare();
    checks++;
    if (in_ready !== exp_ready) fail_line(exp_ready ? "R7 ready" : "R8 ready", 64'(in_ready), 64'(exp_ready));
    checks++;
    if (out_valid !== exp_v) fail_line(exp_v ? {exp_tag, " valid"} : "R9 valid", 64'(out_valid), 64'(exp_v));
    if (exp_v) begin
      checks++;
      if (out_addr !== exp_addr) fail_line({exp_tag, " addr"}, out_addr, exp_addr);
    end
  endtask

  task automatic issue(input bit v, input string tag, input logic [63:0] b, input logic [3:0] bid,
                       input logic [63:0] ix, input bit ie, input logic [1:0] sc,
                       input logic [31:0] d, input bit oe, input logic [2:0] os,
                       input bit lm, input bit lea);
    logic [63:0] off, sb;
    @(negedge clk);
    compare();
    in_valid = v; base_val = b; base_id = bid; index_val = ix; index_en = ie;
    scale_code = sc; disp = d; seg_ovr_en = oe; seg_ovr_sel = os;
    long_mode = lm; lea_mode = lea;
    off = b + (ie ? ix * (64'd1 << sc) : 64'd0) + {{32{d[31]}}, d};
    sb  = lea ? 64'd0 : model_seg(bid, oe, os, lm);
    if (slow_pend) begin
      exp_v = 1; exp_addr = slow_addr; exp_tag = slow_tag; exp_ready = 1; slow_pend = 0;
    end else if (v && exp_ready) begin
      if (sb == 64'd0) begin
        exp_v = 1; exp_addr = off; exp_tag = tag; exp_ready = 1;
      end else begin
        exp_v = 0; exp_ready = 0; slow_pend = 1; slow_addr = sb + off; slow_tag = tag;
      end
    end else begin
      exp_v = 0; exp_ready = 1;
    end
  endtask

  task automatic idle();
    issue(0, "R9", 64'd0, 4'd0, 64'd0, 0, 2'd0, 32'd0, 0, 3'd0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    segtab[0] = 64'h1000;            // ES
    segtab[1] = 64'h0;               // CS
    segtab[2] = 64'h2_0000;          // SS
    segtab[3] = 64'h0;               // DS
    segtab[4] = 64'h7000_0000_0000;  // FS
    segtab[5] = 64'h55;              // GS
    for (int i = 0; i < 6; i++) seg_bases[i*64 +: 64] = segtab[i];
    rst = 1; in_valid = 0; lea_mode = 0; long_mode = 0; base_val = 0; base_id = 0;
    index_val = 0; index_en = 0; scale_code = 0; disp = 0; seg_ovr_en = 0; seg_ovr_sel = 0;
    exp_v = 0; exp_ready = 1; slow_pend = 0; exp_addr = 0; slow_addr = 0;
    exp_tag = "R9"; slow_tag = "R9";
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) fail_line("R1 valid", 64'(out_valid), 64'd0);
      checks++;
      if (in_ready !== 1'b1) fail_line("R1 ready", 64'(in_ready), 64'd1);
    end
    rst = 0;
    idle();
    // R2: each scale, negative and positive displacement, DS base zero
    for (int s = 0; s < 4; s++)
      issue(1, "R2", 64'h1_0000, 4'd3, 64'h10, 1, 2'(s), 32'hFFFF_FFF0, 0, 3'd0, 0, 0);
    issue(1, "R2", 64'hFFFF_FFFF_FFFF_FFFF, 4'd0, 64'd0, 0, 2'd0, 32'd1, 0, 3'd0, 0, 0);
    issue(1, "R2", 64'h8000, 4'd1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 2'd3, 32'h7FFF_FFFF, 0, 3'd0, 0, 0);
    // R3: index ignored when disabled
    issue(1, "R3", 64'h400, 4'd2, 64'hDEAD_BEEF_0000, 0, 2'd3, 32'd8, 0, 3'd0, 0, 0);
    idle();
    // R5 + R8: stack and frame registers pick SS (nonzero) -> slow path
    issue(1, "R5", 64'h100, 4'd4, 64'd2, 1, 2'd1, 32'd4, 0, 3'd0, 0, 0);
    issue(1, "R8", 64'h999, 4'd0, 64'd0, 0, 2'd0, 32'd0, 0, 3'd0, 0, 0); // offered in stall: ignored
    issue(1, "R5", 64'h200, 4'd5, 64'd0, 0, 2'd0, 32'hFFFF_FFFF, 0, 3'd0, 0, 0);
    idle(); idle();
    // R5: overrides ES (slow), CS (fast), 6 and 7 (zero base)
    issue(1, "R5", 64'h10, 4'd4, 64'd0, 0, 2'd0, 32'd0, 1, 3'd0, 0, 0);
    idle();
    issue(1, "R5", 64'h20, 4'd4, 64'd0, 0, 2'd0, 32'd0, 1, 3'd1, 0, 0);
    issue(1, "R5", 64'h30, 4'd5, 64'd0, 0, 2'd0, 32'd0, 1, 3'd6, 0, 0);
    issue(1, "R5", 64'h40, 4'd0, 64'd0, 0, 2'd0, 32'd0, 1, 3'd7, 0, 0);
    issue(1, "R5", 64'h50, 4'd0, 64'd0, 0, 2'd0, 32'd0, 1, 3'd5, 0, 0);
    idle();
    // R6: 64-bit operation zeroes SS/ES, keeps FS/GS
    issue(1, "R6", 64'h60, 4'd4, 64'd0, 0, 2'd0, 32'd0, 0, 3'd0, 1, 0);
    issue(1, "R6", 64'h70, 4'd0, 64'd0, 0, 2'd0, 32'd0, 1, 3'd0, 1, 0);
    issue(1, "R6", 64'h80, 4'd0, 64'd1, 1, 2'd2, 32'd0, 1, 3'd4, 1, 0);
    idle();
    // R4: offset-only mode with a stack register and FS override
    issue(1, "R4", 64'h90, 4'd4, 64'd3, 1, 2'd1, 32'd0, 0, 3'd0, 0, 1);
    issue(1, "R4", 64'hA0, 4'd0, 64'd0, 0, 2'd0, 32'd5, 1, 3'd4, 0, 1);
    // R7: back-to-back fast requests
    for (int k = 0; k < 4; k++)
      issue(1, "R7", 64'(k * 16), 4'd0, 64'd0, 0, 2'd0, 32'd0, 0, 3'd0, 0, 0);
    idle();
    for (int k = 0; k < 300; k++)
      issue(($urandom % 4) != 0, "R2", {$urandom, $urandom}, 4'($urandom), {$urandom, $urandom},
            1'($urandom), 2'($urandom), $urandom, 1'($urandom), 3'($urandom),
            1'($urandom), ($urandom % 4) == 0);
    idle(); idle(); idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule